// File: doc/BRIEF.md
# Pseudo-Random Memory Traffic Checker

This block exercises a memory controller's user port and checks the controller end to end. It stays idle until the controller reports that calibration is done. It then runs a set number of rounds. In each round it writes one burst and then reads the same burst back.

Burst address and burst length come from two free-running shift-register generators. Each value is buffered in its own small FIFO before use. Write beats come from a third generator, which is seeded from the burst address and queued through a write-data FIFO. Returned read beats are queued in a read FIFO. The data generator is then reseeded from the same address, so the expected data is produced again rather than stored, and each returned beat is compared with it.

A directed mode replaces the random address and length with a fixed burst at 16'h1118 of 8 beats. Results are reported as a sticky error flag, a saturating mismatch count, a one-cycle done pulse and a pass level.

Top module: `lfsr_traffic_gen`

## Requirements
- R1: While `calib_done_i` is low and no traffic has started, `req_valid_o` stays low. After reset, all request, data, ready and status outputs are low.
- R2: Each shift register is a Galois right-shift generator: next = (s >> 1) ^ (s[0] ? TAPS : 0). The address generator is 16 bits wide, with seed 16'hACE1 and taps 16'hB400. The length generator is 8 bits wide, with seed 8'h4C and taps 8'hB8. Round k uses the k-th state of each, so the first length is 76 beats.
- R3: When `directed_i` is high, every round uses address 16'h1118 and length 8.
- R4: Each round issues a write request (`req_write_o`=1). Exactly `req_len_o` write beats follow, and `wdata_last_o` is high only on the final beat. Then a read request (`req_write_o`=0) is issued with the same address and length.
- R5: Write beat 0 carries seed = 32'hC0DE0001 XOR the zero-extended address. Each later beat carries the 32-bit Galois step of the previous beat, with taps 32'h80200003.
- R6: Returned beats are compared in order against the regenerated sequence from R5. Each mismatching beat increments `err_cnt_o` (16 bits, saturating) and sets `err_o`, which stays high until reset.
- R7: After the last beat of round `rounds_i` is checked, `done_o` pulses high for exactly one cycle. `pass_o` then goes high and stays high only if no mismatch occurred.
- R8: After `done_o`, no further request is issued.
- R9: While `req_valid_o` or `wdata_valid_o` is high and not yet accepted, that channel's valid and payload hold stable.
- R10: `rdata_ready_o` is low from the acceptance of a write request until the following read request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| calib_done_i | input | 1 | Controller ready for traffic |
| directed_i | input | 1 | Fixed address/length mode |
| rounds_i | input | RW | Number of write/read rounds |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | AW | Burst start address |
| req_len_o | output | LW | Burst length in beats |
| wdata_valid_o | output | 1 | Write beat valid |
| wdata_ready_i | input | 1 | Write beat accepted |
| wdata_o | output | DW | Write beat data |
| wdata_last_o | output | 1 | Final write beat of burst |
| rdata_valid_i | input | 1 | Read beat valid |
| rdata_ready_o | output | 1 | Read beat accepted |
| rdata_i | input | DW | Read beat data |
| err_o | output | 1 | Sticky mismatch flag |
| err_cnt_o | output | 16 | Mismatch count |
| done_o | output | 1 | All rounds finished (pulse) |
| pass_o | output | 1 | Finished without mismatch |

## Verification
A corrupted address or length generator shows up at the very first request, because its address or length departs from the computed sequence. A wrong data seed or data step shows up on the first or second write beat. A read-side reseed that does not match the write side makes the error flag rise, within a few cycles of the first returned beat, even against a perfect memory. Errors injected on purpose must appear as an exact count and a cleared pass level. A miscounted round counter shows up as a done pulse too early, too late or missing, judged against the number of request pairs observed.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WCMD, S_WDATA, S_RCMD, S_RDATA, S_DONE
  } seq_state_e;
endpackage

// File: rtl/tg_lfsr.sv
module tg_lfsr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   TAPS = W'(1),
  parameter logic [W-1:0]   SEED = W'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= load_val_i;
    else if (step_i) q <= (q >> 1) ^ (q[0] ? TAPS : '0);
  end

  assign state_o = q;

  // R2
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) q != '0);
endmodule

// File: rtl/tg_fifo.sv
module tg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_i) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop_i)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (push_i && !pop_i)      cnt <= cnt + 1'b1;
      else if (pop_i && !push_i) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp] <= din_i;
  end

  assign dout_o  = mem[rp];
  assign full_o  = (cnt == (PW+1)'(DEPTH));
  assign empty_o = (cnt == '0);

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) push_i |-> !full_o);
  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) pop_i |-> !empty_o);
endmodule

// File: rtl/lfsr_traffic_gen.sv
module lfsr_traffic_gen
  import tg_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 32,
  parameter int            LW         = 8,
  parameter int            RW         = 8,
  parameter int            CMD_DEPTH  = 4,
  parameter int            DATA_DEPTH = 4,
  parameter logic [AW-1:0] ADDR_SEED  = 16'hACE1,
  parameter logic [AW-1:0] ADDR_TAPS  = 16'hB400,
  parameter logic [LW-1:0] LEN_SEED   = 8'h4C,
  parameter logic [LW-1:0] LEN_TAPS   = 8'hB8,
  parameter logic [DW-1:0] DATA_SEED  = 32'hC0DE0001,
  parameter logic [DW-1:0] DATA_TAPS  = 32'h80200003,
  parameter logic [AW-1:0] DIR_ADDR   = 16'h1118,
  parameter logic [LW-1:0] DIR_LEN    = 8'd8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          calib_done_i,
  input  logic          directed_i,
  input  logic [RW-1:0] rounds_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [LW-1:0] req_len_o,
  output logic          wdata_valid_o,
  input  logic          wdata_ready_i,
  output logic [DW-1:0] wdata_o,
  output logic          wdata_last_o,
  input  logic          rdata_valid_i,
  output logic          rdata_ready_o,
  input  logic [DW-1:0] rdata_i,
  output logic          err_o,
  output logic [15:0]   err_cnt_o,
  output logic          done_o,
  output logic          pass_o
);
  seq_state_e state;

  logic [AW-1:0] addr_q, af_dout, cur_addr;
  logic [LW-1:0] len_q, lf_dout, cur_len;
  logic [LW-1:0] prod_cnt, sent_cnt, chk_cnt;
  logic [RW-1:0] gen_cnt, round_cnt;
  logic [DW-1:0] data_q, rf_dout, wf_dout, dseed;
  logic af_full, af_empty, lf_full, lf_empty;
  logic wf_full, wf_empty, rf_full, rf_empty;
  logic gen_push, start, prod_push, wf_pop, wr_last, rf_push, chk_pop;
  logic mismatch, round_end, last_round, dload;
  logic err_q, done_q, pass_q;
  logic [15:0] ecnt_q;

  function automatic logic [DW-1:0] seed_of(input logic [AW-1:0] a);
    logic [DW-1:0] s;
    s = DATA_SEED ^ DW'(a);
    return (s == '0) ? DATA_SEED : s;
  endfunction

  // generation side: one address/length pair per round
  assign gen_push = calib_done_i && (gen_cnt != rounds_i) && !af_full && !lf_full;

  tg_lfsr #(.W(AW), .TAPS(ADDR_TAPS), .SEED(ADDR_SEED)) u_addr_lfsr (
    .clk_i, .rst_ni, .load_i(1'b0), .load_val_i('0), .step_i(gen_push), .state_o(addr_q));
  tg_lfsr #(.W(LW), .TAPS(LEN_TAPS), .SEED(LEN_SEED)) u_len_lfsr (
    .clk_i, .rst_ni, .load_i(1'b0), .load_val_i('0), .step_i(gen_push), .state_o(len_q));

  tg_fifo #(.W(AW), .DEPTH(CMD_DEPTH)) u_addr_fifo (
    .clk_i, .rst_ni, .push_i(gen_push), .din_i(directed_i ? DIR_ADDR : addr_q),
    .pop_i(start), .dout_o(af_dout), .full_o(af_full), .empty_o(af_empty));
  tg_fifo #(.W(LW), .DEPTH(CMD_DEPTH)) u_len_fifo (
    .clk_i, .rst_ni, .push_i(gen_push), .din_i(directed_i ? DIR_LEN : len_q),
    .pop_i(start), .dout_o(lf_dout), .full_o(lf_full), .empty_o(lf_empty));

  // sequencing
  assign start      = (state == S_IDLE) && calib_done_i && !af_empty && !lf_empty;
  assign prod_push  = ((state == S_WCMD) || (state == S_WDATA)) && (prod_cnt != cur_len) && !wf_full;
  assign wf_pop     = wdata_valid_o && wdata_ready_i;
  assign wr_last    = wf_pop && (sent_cnt == cur_len - 1'b1);
  assign rf_push    = rdata_valid_i && rdata_ready_o;
  assign chk_pop    = (state == S_RDATA) && !rf_empty;
  assign mismatch   = chk_pop && (rf_dout != data_q);
  assign round_end  = chk_pop && (chk_cnt == cur_len - 1'b1);
  assign last_round = round_end && (RW'(round_cnt + 1'b1) == rounds_i);
  assign dload      = start || wr_last;
  assign dseed      = start ? seed_of(af_dout) : seed_of(cur_addr);

  // one data generator serves both phases; reseeded for read-back
  tg_lfsr #(.W(DW), .TAPS(DATA_TAPS), .SEED(DATA_SEED)) u_data_lfsr (
    .clk_i, .rst_ni, .load_i(dload), .load_val_i(dseed),
    .step_i(prod_push || chk_pop), .state_o(data_q));

  tg_fifo #(.W(DW), .DEPTH(DATA_DEPTH)) u_wdata_fifo (
    .clk_i, .rst_ni, .push_i(prod_push), .din_i(data_q),
    .pop_i(wf_pop), .dout_o(wf_dout), .full_o(wf_full), .empty_o(wf_empty));
  tg_fifo #(.W(DW), .DEPTH(DATA_DEPTH)) u_rdata_fifo (
    .clk_i, .rst_ni, .push_i(rf_push), .din_i(rdata_i),
    .pop_i(chk_pop), .dout_o(rf_dout), .full_o(rf_full), .empty_o(rf_empty));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      cur_len   <= '0;
      prod_cnt  <= '0;
      sent_cnt  <= '0;
      chk_cnt   <= '0;
      gen_cnt   <= '0;
      round_cnt <= '0;
    end else begin
      if (gen_push)  gen_cnt  <= gen_cnt + 1'b1;
      if (prod_push) prod_cnt <= prod_cnt + 1'b1;
      if (wf_pop)    sent_cnt <= sent_cnt + 1'b1;
      if (chk_pop)   chk_cnt  <= chk_cnt + 1'b1;
      unique case (state)
        S_IDLE: if (start) begin
          cur_addr <= af_dout;
          cur_len  <= lf_dout;
          prod_cnt <= '0;
          sent_cnt <= '0;
          state    <= S_WCMD;
        end
        S_WCMD:  if (req_ready_i) state <= S_WDATA;
        S_WDATA: if (wr_last) state <= S_RCMD;
        S_RCMD:  if (req_ready_i) begin
          chk_cnt <= '0;
          state   <= S_RDATA;
        end
        S_RDATA: if (round_end) begin
          round_cnt <= round_cnt + 1'b1;
          state     <= last_round ? S_DONE : S_IDLE;
        end
        default: state <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      ecnt_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= last_round;
      if (mismatch) begin
        err_q <= 1'b1;
        if (ecnt_q != 16'hFFFF) ecnt_q <= ecnt_q + 1'b1;
      end
      if (last_round) pass_q <= !(err_q || mismatch);
    end
  end

  assign req_valid_o   = (state == S_WCMD) || (state == S_RCMD);
  assign req_write_o   = (state == S_WCMD);
  assign req_addr_o    = cur_addr;
  assign req_len_o     = cur_len;
  assign wdata_valid_o = (state == S_WDATA) && !wf_empty;
  assign wdata_o       = wf_dout;
  assign wdata_last_o  = (sent_cnt == cur_len - 1'b1);
  assign rdata_ready_o = (state == S_RDATA) && !rf_full;
  assign err_o         = err_q;
  assign err_cnt_o     = ecnt_q;
  assign done_o        = done_q;
  assign pass_o        = pass_q;

  // R1
  calib_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_valid_o) |-> calib_done_i);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_len_o) && $stable(req_write_o));
  // R9
  wdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_valid_o && !wdata_ready_i |=> wdata_valid_o && $stable(wdata_o) && $stable(wdata_last_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) done_o |=> !done_o);
  // R6
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) err_o |=> err_o);
  // R8
  quiet_after_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !req_valid_o);
  // R10
  no_rd_in_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_valid_o |-> !rdata_ready_o);
endmodule

// File: tb/sim_lfsr_traffic_gen.sv
`timescale 1ns/1ps
module sim_lfsr_traffic_gen;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic calib_done_i = 1'b0, directed_i = 1'b0;
  logic [7:0] rounds_i = 8'd1;
  logic req_valid_o, req_ready_i = 1'b0, req_write_o;
  logic [15:0] req_addr_o;
  logic [7:0]  req_len_o;
  logic wdata_valid_o, wdata_ready_i = 1'b0, wdata_last_o;
  logic [31:0] wdata_o;
  logic rdata_valid_i = 1'b0, rdata_ready_o;
  logic [31:0] rdata_i = '0;
  logic err_o, done_o, pass_o;
  logic [15:0] err_cnt_o;

  always #2 clk = ~clk;

  lfsr_traffic_gen u0 (.clk_i(clk), .rst_ni, .calib_done_i, .directed_i, .rounds_i,
    .req_valid_o, .req_ready_i, .req_write_o, .req_addr_o, .req_len_o,
    .wdata_valid_o, .wdata_ready_i, .wdata_o, .wdata_last_o,
    .rdata_valid_i, .rdata_ready_o, .rdata_i, .err_o, .err_cnt_o, .done_o, .pass_o);

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] st16(input logic [15:0] s);
    return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
  endfunction
  function automatic logic [7:0] st8(input logic [7:0] s);
    return (s >> 1) ^ (s[0] ? 8'hB8 : 8'h0);
  endfunction
  function automatic logic [31:0] st32(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction
  function automatic logic [31:0] seed(input logic [15:0] a);
    logic [31:0] s;
    s = 32'hC0DE0001 ^ {16'h0, a};
    return (s == 0) ? 32'hC0DE0001 : s;
  endfunction

  // bench state shared with responder
  logic [31:0] mem [int];
  bit          cmd_w [32];
  logic [15:0] cmd_a [32];
  logic [7:0]  cmd_l [32];
  int cmd_n, done_n, req_seen, rdr_viol, corrupt_left, stall;
  bit wr_phase, rd_active;
  logic [15:0] waddr, raddr;
  logic [7:0]  wlen, rlen;
  int wk, rk;
  logic [31:0] wexp;

  task automatic responder();
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        bit r;
        if (req_valid_o) req_seen++;
        if (done_o) done_n++;
        if (wr_phase && rdata_ready_o) rdr_viol++;
        // request channel
        r = (stall == 0) || ($urandom % 3 != 0);
        if (req_valid_o && r) begin
          if (cmd_n < 32) begin
            cmd_w[cmd_n] = req_write_o; cmd_a[cmd_n] = req_addr_o; cmd_l[cmd_n] = req_len_o;
          end
          cmd_n++;
          if (req_write_o) begin
            wr_phase = 1; waddr = req_addr_o; wlen = req_len_o; wk = 0; wexp = seed(req_addr_o);
          end else begin
            wr_phase = 0; rd_active = 1; raddr = req_addr_o; rlen = req_len_o; rk = 0;
          end
        end
        req_ready_i = r;
        // write data channel
        r = (stall == 0) || ($urandom % 4 != 0);
        if (wdata_valid_o && r) begin
          check(wdata_o == wexp, "R5", "write beat", wdata_o, wexp);
          check(wdata_last_o == (wk == int'(wlen) - 1), "R4", "last flag", wdata_last_o, wk == int'(wlen) - 1);
          mem[int'(waddr + 16'(wk))] = wdata_o;
          wexp = st32(wexp);
          wk++;
        end
        wdata_ready_i = r;
        // read data channel
        r = (stall == 0) || ($urandom % 3 != 0);
        if (rd_active && rdata_ready_o && r) begin
          rdata_valid_i = 1'b1;
          rdata_i = mem[int'(raddr + 16'(rk))];
          if (corrupt_left > 0) begin
            rdata_i = rdata_i ^ 32'h1;
            corrupt_left--;
          end
          rk++;
          if (rk == int'(rlen)) rd_active = 0;
        end else begin
          rdata_valid_i = 1'b0;
        end
      end
    end
  endtask

  task automatic reset_dut(input bit dir, input int rounds, input int stl, input int corrupt);
    @(negedge clk);
    rst_ni = 0; calib_done_i = 0; directed_i = dir; rounds_i = 8'(rounds);
    req_ready_i = 0; wdata_ready_i = 0; rdata_valid_i = 0;
    cmd_n = 0; done_n = 0; req_seen = 0; rdr_viol = 0; corrupt_left = corrupt; stall = stl;
    wr_phase = 0; rd_active = 0; mem.delete();
    repeat (3) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc && done_n == 0; i++) @(negedge clk);
  endtask

  task automatic check_seq(input string rq, input int rounds, input bit dir);
    logic [15:0] a = 16'hACE1;
    logic [7:0]  l = 8'h4C;
    check(cmd_n == 2 * rounds, "R4", "request count", cmd_n, 2 * rounds);
    for (int i = 0; i < rounds; i++) begin
      logic [15:0] ea = dir ? 16'h1118 : a;
      logic [7:0]  el = dir ? 8'd8 : l;
      check(cmd_w[2*i] == 1 && cmd_w[2*i+1] == 0, "R4", "write then read", {cmd_w[2*i], cmd_w[2*i+1]}, 2'b10);
      check(cmd_a[2*i] == ea && cmd_a[2*i+1] == ea, rq, "address", cmd_a[2*i], ea);
      check(cmd_l[2*i] == el && cmd_l[2*i+1] == el, rq, "length", cmd_l[2*i], el);
      a = st16(a); l = st8(l);
    end
  endtask

  task automatic t_reset();
    reset_dut(0, 1, 0, 0);
    check({req_valid_o, wdata_valid_o, rdata_ready_o, err_o, done_o, pass_o} == 6'b0,
          "R1", "outputs after reset", {req_valid_o, wdata_valid_o, rdata_ready_o, err_o, done_o, pass_o}, 0);
    check(err_cnt_o == 0, "R1", "error count after reset", err_cnt_o, 0);
  endtask

  task automatic t_calib_gate();
    reset_dut(0, 1, 0, 0);
    repeat (60) @(negedge clk);
    check(req_seen == 0, "R1", "requests before calibration", req_seen, 0);
    calib_done_i = 1;
    wait_done(2000);
    check(done_n == 1, "R7", "done after single round", done_n, 1);
    check_seq("R2", 1, 0);
  endtask

  task automatic t_random_rounds();
    int seen;
    reset_dut(0, 3, 0, 0);
    calib_done_i = 1;
    wait_done(5000);
    check_seq("R2", 3, 0);
    check(err_o == 0 && err_cnt_o == 0, "R6", "no errors on clean memory", err_cnt_o, 0);
    check(pass_o == 1, "R7", "pass level", pass_o, 1);
    check(rdr_viol == 0, "R10", "read ready during write phase", rdr_viol, 0);
    seen = req_seen;
    repeat (300) @(negedge clk);
    check(req_seen == seen, "R8", "requests after done", req_seen, seen);
    check(done_n == 1, "R7", "single done pulse", done_n, 1);
  endtask

  task automatic t_backpressure();
    reset_dut(0, 2, 1, 0);
    calib_done_i = 1;
    wait_done(8000);
    check_seq("R9", 2, 0);
    check(pass_o == 1 && err_cnt_o == 0, "R9", "stalled run clean", err_cnt_o, 0);
  endtask

  task automatic t_directed();
    reset_dut(1, 2, 0, 0);
    calib_done_i = 1;
    wait_done(2000);
    check_seq("R3", 2, 1);
    check(pass_o == 1, "R3", "directed pass", pass_o, 1);
  endtask

  task automatic t_errors();
    reset_dut(1, 2, 0, 3);
    calib_done_i = 1;
    wait_done(2000);
    check(err_cnt_o == 3, "R6", "mismatch count", err_cnt_o, 3);
    check(err_o == 1, "R6", "sticky flag", err_o, 1);
    check(pass_o == 0, "R7", "pass cleared", pass_o, 0);
    check(done_n == 1, "R7", "done with errors", done_n, 1);
  endtask

  initial begin
    fork responder(); join_none
    t_reset();
    t_calib_gate();
    t_random_rounds();
    t_backpressure();
    t_directed();
    t_errors();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule